// File: doc/BRIEF.md
# Streaming Matrix Transposer

This block takes a continuous stream of matrix elements, one word per enabled clock, and returns the same stream transposed. Each ROWS x COLS matrix arrives in row-major order and leaves in column-major order. The next matrix follows the previous one with no idle cycle between them. Storage is two single-write, single-read memory banks of ROWS*COLS words each. The block writes one bank in arrival order while it reads the other bank in transposed order, and the two banks swap roles at every matrix boundary.

A schedule controller is built around three named states. ST_LEAD discards a fixed number of enabled cycles after reset, so that a source which starts feeding a few cycles after enable is raised still lines up with the matrix boundaries. ST_FILL writes the first matrix while the output stays at zero. ST_STREAM writes one matrix and reads out the previous one in the same cycles. The transitions are as follows. Reset enters ST_LEAD, or ST_FILL when the lead count is zero. ST_LEAD moves to ST_FILL after LEAD_CYCLES enabled cycles. ST_FILL moves to ST_STREAM when the schedule counter wraps for the first time. ST_STREAM then holds until reset.

The read address is the column-major address of the schedule slot. It is chosen from a table of constants through a multiplexer tree of radix MUX_RADIX with PIPE_DEPTH register levels. The write side and the input register are delayed to match those levels. Legal settings have MUX_RADIX equal to a power of two and at least 2, PIPE_DEPTH of zero or more, and MUX_RADIX**PIPE_DEPTH no greater than ROWS*COLS.

Top module: `xpose_stream`

## Requirements
- R1: While reset is held and afterwards until the first transposed word, dout_o is 0. Synchronous reset returns the schedule counter to 0.
- R2: Element (r, c) of a matrix is the input word with index r*COLS+c. The output of that matrix lists all elements with the column index as the outer loop and the row index as the inner loop (c = 0..COLS-1, r = 0..ROWS-1).
- R3: At least four matrices streamed back to back with no idle cycles each come out correctly transposed. The write bank alternates every ROWS*COLS slot cycles.
- R4: The first LEAD_CYCLES enabled cycles after reset are not slots. Words presented in them never appear on dout_o, and the word presented in the next enabled cycle is element (0,0) of the first matrix.
- R5: Element (0,0) of matrix k appears on dout_o exactly ROWS*COLS + PIPE_DEPTH + 2 enabled cycles after the enabled cycle in which it was presented on din_i. Every later output word follows one per enabled cycle.
- R6: While ce_i is low, din_i is ignored, the schedule counter and bank hold, and dout_o holds its value. When ce_i returns high, the ordering carries on unbroken.
- R7: The schedule counter counts from 0 to ROWS*COLS-1 once per enabled slot cycle, then wraps to 0.
- R8: The transposition is correct for a rectangular 4x8 shape and for square shapes 2x2 and 7x7, with pipeline depths 0, 1 and 2 and radices 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Clock enable; low freezes the whole block |
| din_i | input | DW | Input word, row-major order |
| dout_o | output | DW | Transposed output word, column-major order |

## Verification
In every ST_STREAM cycle, the write of the current matrix and the read of the previous matrix happen in the same clock on opposite banks. At the matrix boundary the bank swap also falls in that cycle. The benches stream six matrices back to back and keep a scoreboard of every transposed word across each boundary. This shows that neither access disturbs the other. One stall is placed exactly on a matrix boundary and another in the middle of a matrix, with garbage driven on the input during both. The output must hold during the stall and continue in order afterwards.

// File: rtl/xpose_pkg.sv
`timescale 1ns/1ps
package xpose_pkg;

    typedef enum logic [1:0] {
        ST_LEAD   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } sched_state_e;

endpackage

// File: rtl/xpose_sched.sv
`timescale 1ns/1ps
module xpose_sched
    import xpose_pkg::*;
#(
    parameter int SLOTS       = 32,
    parameter int LEAD_CYCLES = 0,
    localparam int CW         = $clog2(SLOTS)
) (
    input  logic          clk_i,
    input  logic          srst_i,
    input  logic          ce_i,
    output logic          slot_act_o,
    output logic [CW-1:0] idx_o,
    output logic          bank_o,
    output logic          live_o
);

    localparam int LW = (LEAD_CYCLES > 1) ? $clog2(LEAD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(SLOTS - 1);
    localparam logic [LW-1:0] LAST_LEAD = LW'(LEAD_CYCLES - 1);
    localparam sched_state_e RESET_ST = (LEAD_CYCLES > 0) ? ST_LEAD : ST_FILL;

    sched_state_e  state_q, state_d;
    logic [CW-1:0] idx_q, idx_d;
    logic          bank_q, bank_d;
    logic [LW-1:0] lead_q, lead_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= RESET_ST;
            idx_q   <= '0;
            bank_q  <= 1'b0;
            lead_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            bank_q  <= bank_d;
            lead_q  <= lead_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        bank_d  = bank_q;
        lead_d  = lead_q;
        unique case (state_q)
            ST_LEAD: begin
                if (ce_i) begin
                    if (lead_q == LAST_LEAD) begin
                        state_d = ST_FILL;
                    end else begin
                        lead_d = lead_q + 1'b1;
                    end
                end
            end
            ST_FILL, ST_STREAM: begin
                if (ce_i) begin
                    if (idx_q == LAST_IDX) begin
                        idx_d   = '0;
                        bank_d  = ~bank_q;
                        state_d = ST_STREAM;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = RESET_ST;
        endcase
    end

    // outputs
    always_comb begin
        slot_act_o = ce_i && (state_q != ST_LEAD);
        live_o     = (state_q == ST_STREAM);
        idx_o      = idx_q;
        bank_o     = bank_q;
    end

endmodule

// File: rtl/xpose_addr_tree.sv
`timescale 1ns/1ps
module xpose_addr_tree #(
    parameter int ROWS      = 4,
    parameter int COLS      = 8,
    parameter int RADIX     = 2,
    parameter int DEPTH     = 2,
    localparam int CW       = $clog2(ROWS * COLS)
) (
    input  logic          clk_i,
    input  logic          srst_i,
    input  logic          ce_i,
    input  logic [CW-1:0] idx_i,
    output logic [CW-1:0] addr_o
);

    localparam int SLOTS = ROWS * COLS;
    localparam int P2    = 1 << CW;
    localparam int LB    = $clog2(RADIX);
    localparam int RB    = CW - DEPTH * LB;

    // column-major read address of schedule slot i
    function automatic logic [CW-1:0] leaf(input int i);
        if (i >= SLOTS) begin
            return '0;
        end
        return CW'((i % ROWS) * COLS + (i / ROWS));
    endfunction

    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
        localparam int WO = P2 >> ((l + 1) * LB);
        localparam int PW = $clog2(P2 >> (l * LB));
        logic [CW-1:0] q [WO];
        logic [CW-1:0] idx_q;

        if (l == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (srst_i) begin
                    idx_q <= '0;
                    for (int j = 0; j < WO; j++) q[j] <= '0;
                end else if (ce_i) begin
                    idx_q <= idx_i;
                    for (int j = 0; j < WO; j++) begin
                        q[j] <= leaf(j * RADIX + int'(idx_i[LB-1:0]));
                    end
                end
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (srst_i) begin
                    idx_q <= '0;
                    for (int j = 0; j < WO; j++) q[j] <= '0;
                end else if (ce_i) begin
                    idx_q <= g_lvl[l-1].idx_q;
                    for (int j = 0; j < WO; j++) begin
                        q[j] <= g_lvl[l-1].q[PW'(j * RADIX) + PW'(g_lvl[l-1].idx_q[l*LB +: LB])];
                    end
                end
            end
        end
    end

    if (DEPTH == 0) begin : g_flat
        assign addr_o = leaf(int'(idx_i));
    end else if (RB == 0) begin : g_root
        logic unused_sel;
        assign unused_sel = ^g_lvl[DEPTH-1].idx_q;
        assign addr_o = g_lvl[DEPTH-1].q[0];
    end else begin : g_tail
        logic unused_sel;
        assign unused_sel = ^g_lvl[DEPTH-1].idx_q[CW-RB-1:0];
        assign addr_o = g_lvl[DEPTH-1].q[g_lvl[DEPTH-1].idx_q[CW-1 -: RB]];
    end

endmodule

// File: rtl/xpose_bank.sv
`timescale 1ns/1ps
module xpose_bank #(
    parameter int DW      = 16,
    parameter int ENTRIES = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk_i,
    input  logic          ce_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk_i) begin
        if (ce_i) begin
            if (we_i) begin
                mem[waddr_i] <= wdata_i;
            end
            rdata_o <= mem[raddr_i];
        end
    end

endmodule

// File: rtl/xpose_stream.sv
`timescale 1ns/1ps
module xpose_stream #(
    parameter int DW          = 16,
    parameter int ROWS        = 4,
    parameter int COLS        = 8,
    parameter int LEAD_CYCLES = 0,
    parameter int MUX_RADIX   = 2,
    parameter int PIPE_DEPTH  = 2
) (
    input  logic          clk_i,
    input  logic          srst_i,
    input  logic          ce_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o
);

    localparam int SLOTS = ROWS * COLS;
    localparam int AW    = $clog2(SLOTS);
    localparam int ACC   = PIPE_DEPTH + 1;

    typedef struct packed {
        logic          wr;
        logic          live;
        logic          bank;
        logic [AW-1:0] idx;
        logic [DW-1:0] data;
    } slot_t;

    logic          slot_act;
    logic [AW-1:0] sched_idx;
    logic          sched_bank;
    logic          sched_live;
    logic [AW-1:0] tree_addr;
    logic [AW-1:0] rd_addr_q;
    slot_t         cur;
    slot_t         pipe_q [ACC];
    slot_t         acc;
    logic          out_live_q;
    logic          out_bank_q;
    logic [DW-1:0] rdata_b [2];

    xpose_sched #(
        .SLOTS       (SLOTS),
        .LEAD_CYCLES (LEAD_CYCLES)
    ) u_sched (
        .clk_i      (clk_i),
        .srst_i     (srst_i),
        .ce_i       (ce_i),
        .slot_act_o (slot_act),
        .idx_o      (sched_idx),
        .bank_o     (sched_bank),
        .live_o     (sched_live)
    );

    xpose_addr_tree #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .RADIX (MUX_RADIX),
        .DEPTH (PIPE_DEPTH)
    ) u_tree (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .ce_i   (ce_i),
        .idx_i  (sched_idx),
        .addr_o (tree_addr)
    );

    always_comb begin
        cur.wr   = slot_act;
        cur.live = sched_live;
        cur.bank = sched_bank;
        cur.idx  = sched_idx;
        cur.data = din_i;
    end

    // input register followed by write-side alignment stages
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            for (int s = 0; s < ACC; s++) pipe_q[s] <= '0;
            rd_addr_q <= '0;
        end else if (ce_i) begin
            pipe_q[0] <= cur;
            for (int s = 1; s < ACC; s++) pipe_q[s] <= pipe_q[s-1];
            rd_addr_q <= tree_addr;
        end
    end

    assign acc = pipe_q[ACC-1];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        xpose_bank #(
            .DW      (DW),
            .ENTRIES (SLOTS)
        ) u_bank (
            .clk_i   (clk_i),
            .ce_i    (ce_i),
            .we_i    (acc.wr && (acc.bank == 1'(b))),
            .waddr_i (acc.idx),
            .wdata_i (acc.data),
            .raddr_i (rd_addr_q),
            .rdata_o (rdata_b[b])
        );
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            out_live_q <= 1'b0;
            out_bank_q <= 1'b0;
        end else if (ce_i) begin
            out_live_q <= acc.live;
            out_bank_q <= ~acc.bank;
        end
    end

    always_comb begin
        dout_o = out_live_q ? rdata_b[out_bank_q] : '0;
    end

endmodule

// File: rtl/xpose_stream_chk.sv
`timescale 1ns/1ps
module xpose_stream_chk #(
    parameter int DW          = 16,
    parameter int ROWS        = 4,
    parameter int COLS        = 8,
    parameter int LEAD_CYCLES = 0,
    parameter int PIPE_DEPTH  = 2,
    localparam int AW         = $clog2(ROWS * COLS)
) (
    input logic          clk_i,
    input logic          srst_i,
    input logic          ce_i,
    input logic [DW-1:0] dout_o,
    input logic          slot_act,
    input logic [AW-1:0] idx,
    input logic          bank
);

    localparam int SLOTS = ROWS * COLS;
    localparam int LAT   = SLOTS + PIPE_DEPTH + 2;
    localparam logic [AW-1:0] LAST_IDX = AW'(SLOTS - 1);

    logic seen;
    int   en_cnt;
    int   slot_cnt;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            seen     <= 1'b0;
            en_cnt   <= 0;
            slot_cnt <= 0;
        end else begin
            seen <= 1'b1;
            if (ce_i && en_cnt < LEAD_CYCLES) en_cnt <= en_cnt + 1;
            if (slot_act && slot_cnt < LAT) slot_cnt <= slot_cnt + 1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (srst_i) idx <= LAST_IDX); // R7
    AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (srst_i) (slot_act && idx == LAST_IDX) |=> (idx == '0)); // R7
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (srst_i) (slot_act && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1)); // R7
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (srst_i) !ce_i |=> $stable(idx)); // R6
    AST_BANK_FLIP: assert property (@(posedge clk_i) disable iff (srst_i) (slot_act && idx == LAST_IDX) |=> (bank != $past(bank))); // R3
    AST_BANK_KEEP: assert property (@(posedge clk_i) disable iff (srst_i) !(slot_act && idx == LAST_IDX) |=> $stable(bank)); // R3
    AST_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (srst_i) (en_cnt < LEAD_CYCLES) |-> !slot_act); // R4
    AST_LEAD_DONE: assert property (@(posedge clk_i) disable iff (srst_i) (en_cnt >= LEAD_CYCLES) |-> (slot_act == ce_i)); // R4
    AST_QUIET_OUT: assert property (@(posedge clk_i) disable iff (srst_i) (slot_cnt < LAT) |-> (dout_o == '0)); // R5
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (srst_i) (seen && !$past(ce_i)) |-> $stable(dout_o)); // R6

endmodule

bind xpose_stream xpose_stream_chk #(
    .DW          (DW),
    .ROWS        (ROWS),
    .COLS        (COLS),
    .LEAD_CYCLES (LEAD_CYCLES),
    .PIPE_DEPTH  (PIPE_DEPTH)
) u_chk (
    .clk_i    (clk_i),
    .srst_i   (srst_i),
    .ce_i     (ce_i),
    .dout_o   (dout_o),
    .slot_act (slot_act),
    .idx      (sched_idx),
    .bank     (sched_bank)
);

// File: tb/xpose_stream_lane.sv
`timescale 1ns/1ps
module xpose_stream_lane #(
    parameter int          ROWS  = 4,
    parameter int          COLS  = 8,
    parameter int          LEAD  = 0,
    parameter int          RADIX = 2,
    parameter int          DEPTH = 2,
    parameter logic [15:0] SEED  = 16'h0000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done,
    output int   n_cmp,
    output int   n_bad
);

    localparam int N   = ROWS * COLS;
    localparam int LAT = N + DEPTH + 2;

    logic        en;
    logic [15:0] din;
    logic [15:0] dout;
    logic [15:0] exp_q [$];
    logic        fed;
    logic        in_stall;
    logic [15:0] hold_val;
    int          etick;
    int          popped;

    xpose_stream #(
        .DW          (16),
        .ROWS        (ROWS),
        .COLS        (COLS),
        .LEAD_CYCLES (LEAD),
        .MUX_RADIX   (RADIX),
        .PIPE_DEPTH  (DEPTH)
    ) u_dut (
        .clk_i  (clk),
        .srst_i (rst),
        .ce_i   (en),
        .din_i  (din),
        .dout_o (dout)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lane %0dx%0d: actual %h expected %h", tag, ROWS, COLS, act, exp);
        end
    endtask

    task automatic tick(input logic e, input logic [15:0] d);
        @(posedge clk);
        #1;
        en  = e;
        din = d;
    endtask

    // driver: feeds matrices and pushes the expected transposed words
    initial begin
        en = 0; din = 0; fed = 0; done = 0; n_cmp = 0; n_bad = 0;
        wait (start);
        repeat (2) begin
            @(negedge clk);
            check("R1", dout, 16'h0000);
        end
        for (int i = 0; i < LEAD; i++) tick(1'b1, 16'hDEAD ^ 16'(i));
        for (int m = 0; m < 6; m++) begin
            for (int w = 0; w < N; w++) begin
                if (m < 4 && w == 0) begin
                    for (int c = 0; c < COLS; c++)
                        for (int r = 0; r < ROWS; r++)
                            exp_q.push_back(SEED + 16'(m * N + r * COLS + c));
                end
                if (m == 2 && w == 0) repeat (3) tick(1'b0, 16'h5A5A);
                if (m == 3 && w == N / 2) repeat (2) tick(1'b0, 16'hA5A5);
                tick(1'b1, SEED + 16'(m * N + w));
                fed = 1;
            end
        end
        tick(1'b0, 16'h0000);
        repeat (2) @(posedge clk);
        check("R8", 16'(exp_q.size()), 16'h0000);
        done = 1;
    end

    // monitor: scoreboard on enabled cycles, hold check on stalled cycles
    initial begin
        in_stall = 0; hold_val = 0; etick = 0; popped = 0;
        forever begin
            @(negedge clk);
            if (!fed) begin
                if (en) check("R4", dout, 16'h0000);
            end else if (en) begin
                if (in_stall) begin
                    check("R6", dout, hold_val);
                    in_stall = 0;
                end
                if (etick < LAT) begin
                    check("R5", dout, 16'h0000);
                end else if (exp_q.size() > 0) begin
                    if (popped < N)
                        check((LEAD > 0) ? "R4" : "R2", dout, exp_q.pop_front());
                    else if (popped < 2 * N)
                        check("R3", dout, exp_q.pop_front());
                    else
                        check("R7", dout, exp_q.pop_front());
                    popped++;
                end
                etick++;
            end else begin
                if (!in_stall) begin
                    in_stall = 1;
                    hold_val = dout;
                end else begin
                    check("R6", dout, hold_val);
                end
            end
        end
    end

endmodule

// File: tb/xpose_stream_tb.sv
`timescale 1ns/1ps
module xpose_stream_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done_a, done_b, done_c;
    int   cmp_a, cmp_b, cmp_c;
    int   bad_a, bad_b, bad_c;
    int   total_cmp, total_bad;
    logic timed_out = 1'b0;

    always #2 clk = ~clk;

    xpose_stream_lane #(.ROWS(4), .COLS(8), .LEAD(2), .RADIX(2), .DEPTH(2), .SEED(16'h8000))
        u_lane_a (.clk(clk), .rst(rst), .start(start), .done(done_a), .n_cmp(cmp_a), .n_bad(bad_a));
    xpose_stream_lane #(.ROWS(2), .COLS(2), .LEAD(0), .RADIX(2), .DEPTH(0), .SEED(16'h0100))
        u_lane_b (.clk(clk), .rst(rst), .start(start), .done(done_b), .n_cmp(cmp_b), .n_bad(bad_b));
    xpose_stream_lane #(.ROWS(7), .COLS(7), .LEAD(3), .RADIX(4), .DEPTH(1), .SEED(16'h4000))
        u_lane_c (.clk(clk), .rst(rst), .start(start), .done(done_c), .n_cmp(cmp_c), .n_bad(bad_c));

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst   = 1'b0;
        start = 1'b1;
        fork
            wait (done_a && done_b && done_c);
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        total_cmp = cmp_a + cmp_b + cmp_c;
        total_bad = bad_a + bad_b + bad_c;
        if (timed_out) begin
            total_cmp++;
            total_bad++;
            $display("FAIL watchdog R8: actual not done expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_cmp, total_bad);
        $finish;
    end

endmodule